// File: doc/BRIEF.md
# Per-bit flagged CAN frame bit transmitter

This block plays one CAN frame onto the bus from a list of raw bit entries held in an external memory. It builds no fields. Each entry supplies the level to drive, four behaviour flags and an index into an external table of bit lengths. Because every bit has its own behaviour and its own length, a test fixture can send malformed frames, frames with distorted timing, and frames that end or yield at any chosen point.

After a start strobe the block walks the entries from address 0. It drives `tx_o` for the length that the table gives, reads the bus back on `rx_i` at a fixed fraction of that length, and applies the flags of the entry to the value it reads. When the frame ends or arbitration is lost, it raises a one-cycle done pulse with a three-bit status word. One clock cycle is one 20 ns length step.

Top module: `can_bitseq_tx`

## Requirements
- R1: `tx_o` drives the level in entry bit 11 while a bit is being sent (0 dominant, 1 recessive). It is recessive during reset, when idle and after any stop. The bus is the wired-AND of `tx_o` and the other nodes.
- R2: If arbitration flag bit 10 is set, the entry level is 1 and the read-back is 0, the frame stops at once. Done follows on the next clock, with status bit 0 set and no bit error counted for that bit.
- R3: The frame ends after the whole bit whose last flag, entry bit 9, is set.
- R4: If ACK flag bit 8 is set and the read-back is 1, status bit 1 (acknowledge error) is set. The frame continues.
- R5: If check flag bit 7 is set, a read-back that differs from the level sets status bit 2 (bit error). If it is clear, a mismatch has no effect. The frame continues.
- R6: Entry bits 6:0 index the length table. A bit lasts the table value in clock cycles, and a value of 0 counts as 1.
- R7: The read-back is taken only in bit cycle floor(L*SAMPLE_Q8/256), clamped to L-1, where L is the bit length (default SAMPLE_Q8=192, 75 percent). Bus activity in any other cycle of the bit has no effect.
- R8: `done_o` is high for exactly one cycle when a frame stops. `status_o` is cleared at an accepted start, accumulates during the frame, and holds its final value until the next start.
- R9: A start strobe while busy is ignored.
- R10: The frame ends after entry DEPTH-1 (default 256 entries) even if no last flag is seen.
- R11: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` is high, where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one length step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| busy_o | output | 1 | Frame in progress |
| ent_addr_o | output | AW (8) | Entry memory address (next entry while busy, 0 when idle) |
| ent_data_i | input | 12 | Entry read data, combinational from address |
| dur_idx_o | output | 7 | Length table index of the current bit |
| dur_val_i | input | DUR_W (12) | Length of the indexed entry in cycles |
| tx_o | output | 1 | Transmit line |
| rx_i | input | 1 | Bus read-back |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| status_o | output | 3 | {bit error, ack error, arbitration lost} |

## Verification
A table of bus-interference patterns is run against one seven-bit frame. The patterns are: no other node, an acknowledging node, dominant windows over the arbitration bits, dominant windows over checked and unchecked recessive bits, and one-cycle dominant glitches just before and exactly at the sample cycle. Together they separate arbitration loss, acknowledge error, bit error and ignored mismatches, and they show the read-back cycle. A second frame with mixed lengths, including a zero length, checks bit timing and the 75 percent point through the cycle count, the transmit trace and glitch placement. Further directed runs cover a restart strobe during a frame and a frame with no last flag that must stop at the memory depth.

// File: rtl/can_bitseq_pkg.sv
package can_bitseq_pkg;

    localparam int IDX_W = 7;

    typedef struct packed {
        logic             level;
        logic             f_arb;
        logic             f_last;
        logic             f_ack;
        logic             f_chk;
        logic [IDX_W-1:0] dur_idx;
    } bit_ent_t;

    localparam int ENT_W = $bits(bit_ent_t);

    typedef struct packed {
        logic bit_err;
        logic ack_err;
        logic arb_lost;
    } seq_stat_t;

    localparam int STAT_W = $bits(seq_stat_t);

    function automatic seq_stat_t stat_or(seq_stat_t a, seq_stat_t b);
        seq_stat_t r;
        r.bit_err  = a.bit_err  | b.bit_err;
        r.ack_err  = a.ack_err  | b.ack_err;
        r.arb_lost = a.arb_lost | b.arb_lost;
        return r;
    endfunction

endpackage

// File: rtl/can_bitseq_timer.sv
module can_bitseq_timer #(
    parameter int DUR_W     = 12,
    parameter int SAMPLE_Q8 = 192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             kill_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             samp_o,
    output logic             end_o
);
    localparam int PW = DUR_W + 9;

    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] last_c;
    logic [PW-1:0]    prod_c;
    logic [DUR_W-1:0] spt_c;

    always_comb begin
        last_c = (dur_i == '0) ? '0 : dur_i - 1'b1;
        prod_c = PW'(dur_i) * PW'(SAMPLE_Q8);
        spt_c  = DUR_W'(prod_c >> 8);
        if (PW'(spt_c) != (prod_c >> 8) || spt_c > last_c) begin
            spt_c = last_c;
        end
    end

    assign samp_o = run_i && (cnt_q == spt_c);
    assign end_o  = run_i && (cnt_q == last_c);

    always_ff @(posedge clk) begin
        if (rst || !run_i || end_o || kill_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst || end_o || !run_i || kill_i) begin
            seen_q <= 1'b0;
        end else if (samp_o) begin
            seen_q <= 1'b1;
        end
    end

    // every bit that completes has been sampled exactly within it
    p_samp_in_bit_r7: assert property (@(posedge clk) disable iff (rst)
        end_o |-> (seen_q || samp_o));

endmodule

// File: rtl/can_bitseq_judge.sv
module can_bitseq_judge
    import can_bitseq_pkg::*;
(
    input  bit_ent_t  ent_i,
    input  logic      samp_i,
    input  logic      rx_i,
    output seq_stat_t hit_o
);
    always_comb begin
        hit_o.arb_lost = samp_i && ent_i.f_arb && ent_i.level && !rx_i;
        hit_o.ack_err  = samp_i && ent_i.f_ack && rx_i;
        hit_o.bit_err  = samp_i && ent_i.f_chk && (rx_i != ent_i.level)
                         && !hit_o.arb_lost;
    end
endmodule

// File: rtl/can_bitseq_tx.sv
module can_bitseq_tx
    import can_bitseq_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int DUR_W     = 12,
    parameter int SAMPLE_Q8 = 192,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic [AW-1:0]     ent_addr_o,
    input  logic [ENT_W-1:0]  ent_data_i,
    output logic [IDX_W-1:0]  dur_idx_o,
    input  logic [DUR_W-1:0]  dur_val_i,
    output logic              tx_o,
    input  logic              rx_i,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic      busy_q;
    logic      done_q;
    logic [AW-1:0] addr_q;
    bit_ent_t  ent_q;
    seq_stat_t st_q;
    seq_stat_t st_d;
    seq_stat_t hit;
    logic      samp;
    logic      bend;
    logic      fin;
    logic      adv;

    can_bitseq_timer #(.DUR_W(DUR_W), .SAMPLE_Q8(SAMPLE_Q8)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy_q),
        .kill_i (fin),
        .dur_i  (dur_val_i),
        .samp_o (samp),
        .end_o  (bend)
    );

    can_bitseq_judge u_judge (
        .ent_i  (ent_q),
        .samp_i (samp),
        .rx_i   (rx_i),
        .hit_o  (hit)
    );

    always_comb begin
        st_d = stat_or(st_q, hit);
        fin  = busy_q && (hit.arb_lost ||
                          (bend && (ent_q.f_last || addr_q == LAST_ADDR)));
        adv  = busy_q && bend && !fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            addr_q <= '0;
            ent_q  <= '0;
            st_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    addr_q <= '0;
                    ent_q  <= bit_ent_t'(ent_data_i);
                    st_q   <= '0;
                end
            end else begin
                st_q <= st_d;
                if (fin) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else if (adv) begin
                    addr_q <= addr_q + 1'b1;
                    ent_q  <= bit_ent_t'(ent_data_i);
                end
            end
        end
    end

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign status_o   = st_q;
    assign tx_o       = busy_q ? ent_q.level : 1'b1;
    assign dur_idx_o  = ent_q.dur_idx;
    assign ent_addr_o = busy_q ? addr_q + 1'b1 : '0;

    p_arb_halt_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && hit.arb_lost) |=> (done_o && status_o[0] && tx_o && !busy_o));

    p_last_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bend && ent_q.f_last) |=> (!busy_o && done_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_restart_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && !fin) |=>
            (busy_q && (addr_q == $past(addr_q) || addr_q == $past(addr_q) + 1'b1)));

endmodule

// File: tb/can_bitseq_tx_tb.sv
module can_bitseq_tx_tb;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_o;
    logic [7:0]  ent_addr_o;
    logic [11:0] ent_data_i;
    logic [6:0]  dur_idx_o;
    logic [11:0] dur_val_i;
    logic        tx_o;
    logic        rx_i;
    logic        done_o;
    logic [2:0]  status_o;
    logic        ext_n = 1'b1;

    logic [11:0] mem  [0:255];
    logic [11:0] dtab [0:127];
    logic        tx_tr   [0:511];
    logic        busy_tr [0:511];

    int checks = 0;
    int bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ent_data_i = mem[ent_addr_o];
    assign dur_val_i  = dtab[dur_idx_o];
    assign rx_i       = tx_o & ext_n;

    can_bitseq_tx u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
        .ent_addr_o(ent_addr_o), .ent_data_i(ent_data_i),
        .dur_idx_o(dur_idx_o), .dur_val_i(dur_val_i),
        .tx_o(tx_o), .rx_i(rx_i), .done_o(done_o), .status_o(status_o)
    );

    // entry: {level, arb, last, ack, chk, idx[6:0]}
    function automatic logic [11:0] mk(bit lv, bit ar, bit ls, bit ak, bit ck, int ix);
        return {lv, ar, ls, ak, ck, 7'(ix)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input bit ack_drv, input int ws, input int wl, input int rs,
                             output int cyc, output logic [2:0] st, output bit post_ok);
        cyc = -1;
        st  = '0;
        @(negedge clk);
        start_i = 1'b1;
        ext_n   = 1'b1;
        @(posedge clk);
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            start_i   = (rs != 0 && c == rs);
            tx_tr[c]  = tx_o;
            busy_tr[c] = busy_o;
            if (done_o) begin
                cyc = c;
                st  = status_o;
                break;
            end
            ext_n = !((wl != 0 && c >= ws && c < ws + wl) ||
                      (ack_drv && c >= 16 && c < 20));
            @(posedge clk);
        end
        start_i = 1'b0;
        ext_n   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        post_ok = !done_o && tx_o && (status_o == st);
    endtask

    typedef struct packed {
        logic       ack;
        logic [8:0] ws;
        logic [8:0] wl;
        logic [8:0] rs;
        logic [2:0] st;
        logic [8:0] cyc;
        logic [3:0] req;
    } vec_t;

    // status bits: [0] arbitration lost (R2), [1] ack error (R4), [2] bit error (R5)
    localparam vec_t VECS [9] = '{
        '{1'b1, 9'd0,  9'd0, 9'd0,  3'b000, 9'd28, 4'd3},
        '{1'b0, 9'd0,  9'd0, 9'd0,  3'b010, 9'd28, 4'd4},
        '{1'b1, 9'd0,  9'd4, 9'd0,  3'b001, 9'd4,  4'd2},
        '{1'b1, 9'd8,  9'd4, 9'd0,  3'b001, 9'd12, 4'd2},
        '{1'b1, 9'd12, 9'd4, 9'd0,  3'b100, 9'd28, 4'd5},
        '{1'b1, 9'd2,  9'd1, 9'd0,  3'b000, 9'd28, 4'd7},
        '{1'b1, 9'd15, 9'd1, 9'd0,  3'b100, 9'd28, 4'd7},
        '{1'b1, 9'd20, 9'd4, 9'd0,  3'b000, 9'd28, 4'd5},
        '{1'b1, 9'd0,  9'd0, 9'd10, 3'b000, 9'd28, 4'd9}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [2:0] st;
        bit post_ok;

        for (int i = 0; i < 128; i++) dtab[i] = 12'd4;
        dtab[1] = 12'd8;
        dtab[2] = 12'd10;
        dtab[4] = 12'd0;
        for (int i = 0; i < 256; i++) mem[i] = mk(1, 0, 0, 0, 0, 0);
        // frame A: seven bits of length 4
        mem[0] = mk(1, 1, 0, 0, 1, 0);
        mem[1] = mk(0, 0, 0, 0, 1, 0);
        mem[2] = mk(1, 1, 0, 0, 1, 0);
        mem[3] = mk(1, 0, 0, 0, 1, 0);
        mem[4] = mk(1, 0, 0, 1, 0, 0);
        mem[5] = mk(1, 0, 0, 0, 0, 0);
        mem[6] = mk(1, 0, 1, 0, 1, 0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 / R11 / R8 reset state
        chk(tx_o == 1'b1, "R1 reset tx", tx_o, 1);
        chk(busy_o == 1'b0, "R11 reset busy", busy_o, 0);
        chk(done_o == 1'b0 && status_o == 3'b000, "R8 reset done/status", {done_o, status_o}, 0);
        rst = 1'b0;

        foreach (VECS[i]) begin
            run_frame(VECS[i].ack, int'(VECS[i].ws), int'(VECS[i].wl), int'(VECS[i].rs),
                      cyc, st, post_ok);
            chk(cyc == int'(VECS[i].cyc), $sformatf("R%0d vec%0d cycles", VECS[i].req, i),
                cyc, int'(VECS[i].cyc));
            chk(st == VECS[i].st, $sformatf("R%0d vec%0d status", VECS[i].req, i),
                int'(st), int'(VECS[i].st));
            chk(post_ok, $sformatf("R8 vec%0d single pulse and held status", i), post_ok, 1);
        end

        // R1: levels follow entries, recessive at done; R11 busy window
        run_frame(1'b1, 0, 0, 0, cyc, st, post_ok);
        chk(tx_tr[0] == 1'b1 && tx_tr[4] == 1'b0 && tx_tr[7] == 1'b0 && tx_tr[8] == 1'b1,
            "R1 tx trace frame A", {tx_tr[0], tx_tr[4], tx_tr[7], tx_tr[8]}, 4'b1001);
        chk(tx_tr[28] == 1'b1, "R1 tx recessive at done", tx_tr[28], 1);
        chk(busy_tr[0] == 1'b1 && busy_tr[27] == 1'b1 && busy_tr[28] == 1'b0,
            "R11 busy window", {busy_tr[0], busy_tr[27], busy_tr[28]}, 3'b110);

        // R2: after arbitration loss at bit 0, the dominant bit 1 is never sent
        run_frame(1'b1, 0, 4, 0, cyc, st, post_ok);
        chk(tx_tr[4] == 1'b1, "R2 tx recessive after arbitration loss", tx_tr[4], 1);

        // frame B: lengths 8, 10 and 0 (counts as 1)
        mem[0] = mk(0, 0, 0, 0, 1, 1);
        mem[1] = mk(1, 0, 0, 0, 1, 2);
        mem[2] = mk(1, 0, 1, 0, 1, 4);
        run_frame(1'b0, 0, 0, 0, cyc, st, post_ok);
        chk(cyc == 19, "R6 mixed lengths total", cyc, 19);
        chk(tx_tr[7] == 1'b0 && tx_tr[8] == 1'b1, "R6 bit boundary at 8",
            {tx_tr[7], tx_tr[8]}, 2'b01);
        chk(st == 3'b000, "R6 clean status", st, 0);
        run_frame(1'b0, 14, 1, 0, cyc, st, post_ok);
        chk(st == 3'b000, "R7 glitch before sample of 10-cycle bit", st, 0);
        run_frame(1'b0, 15, 1, 0, cyc, st, post_ok);
        chk(st == 3'b100, "R7 glitch at sample of 10-cycle bit", st, 4);
        run_frame(1'b0, 16, 1, 0, cyc, st, post_ok);
        chk(st == 3'b000, "R7 glitch after sample of 10-cycle bit", st, 0);

        // frame D: no last flag, length 1 each
        for (int i = 0; i < 256; i++) mem[i] = mk(1, 0, 0, 0, 0, 4);
        run_frame(1'b0, 0, 0, 0, cyc, st, post_ok);
        chk(cyc == 256, "R10 depth limit ends frame", cyc, 256);
        chk(post_ok, "R10 done pulse after depth limit", post_ok, 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule